// File: doc/BRIEF.md
# Credit-Gated Wormhole Output Port Arbiter

This block is the control for a single output port of a wormhole-switched on-chip router. Every input port presents at most one flit at a time. Each flit carries a service level and a flit kind (header, body, tail). Each service level has its own lane. A lane that holds no packet picks among the header flits for its level in round-robin order. Once a header wins, the lane is locked to that input until the tail flit of the packet has passed. After the tail, the round-robin pointer moves to the input just past the one that owned the lane.

A credit counter per service level tracks the free slots in the next router's buffer for that level. A flit of a level leaves only while its counter is non-zero. When more than one lane can send in the same cycle, the lowest-numbered level, which is the most urgent, takes the port. At most one flit leaves per cycle. The acknowledge to the chosen input is combinational in the cycle the flit is presented, so the input buffer pops it at the next edge. The registered crossbar select and the outgoing flit appear one cycle later.

The block sits between the input buffers and the crossbar of each output. The routing decision is made upstream, so every flit presented here is already destined for this output.

Top module: `noc_oport_arb`

## Requirements
- R1: After reset, `out_type` is idle (00), `xbar_sel`, `out_sl`, `out_data` and `in_ack` are zero, every lane is unlocked with its round-robin pointer at input 0, and every credit counter holds `CREDIT_DEPTH`.
- R2: Flit kinds are encoded as idle 00, header 01, body 10 and tail 11. On an unlocked lane, the header flits whose `req_sl` equals the lane's level are searched starting at the lane's pointer, moving towards higher input numbers and wrapping. The first one found is the candidate.
- R3: Once a header is sent on a lane, that lane accepts only body or tail flits of that level from the same input. Headers of that level from other inputs are not acknowledged until the tail has been sent.
- R4: When a tail is sent, its lane unlocks and the lane's pointer becomes the owner's index plus one, wrapping from `N_IN-1` to 0.
- R5: When candidates of several levels have credit in the same cycle, the lowest level number is sent.
- R6: A level's credit counter drops by one for each flit of that level sent and rises by one for each cycle its `credit_ret` bit is high. No flit of a level is sent while its counter is zero.
- R7: `in_ack` has at most one bit set. It is set, in the same cycle, for the input whose flit is sent.
- R8: The cycle after a flit is sent, `out_type`, `out_sl` and `out_data` show that flit and `xbar_sel` is the one-hot code of its input. After a cycle in which nothing is sent, `out_type` is idle and the other three outputs are zero.
- R9: A presented flit of kind idle is never acknowledged. A body or tail flit is never acknowledged on an unlocked lane. A header is never acknowledged on a locked lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | N_IN | A flit is presented by input i |
| req_sl | input | N_IN*SL_W | Service level of input i's flit, bits [i*SL_W +: SL_W] |
| req_type | input | N_IN*2 | Flit kind of input i, bits [i*2 +: 2] |
| req_data | input | N_IN*FLIT_W | Payload of input i, bits [i*FLIT_W +: FLIT_W] |
| credit_ret | input | N_SL | One pulse per freed downstream slot, per level |
| in_ack | output | N_IN | Flit of input i is taken this cycle |
| xbar_sel | output | N_IN | Registered one-hot crossbar select |
| out_type | output | 2 | Registered outgoing flit kind |
| out_sl | output | SL_W | Registered outgoing service level |
| out_data | output | FLIT_W | Registered outgoing payload |

## Verification
Three headers of the same level arrive at once. This shows whether the round-robin search order is correct and whether a lane stays locked through its owner's body flits. A second pair of headers that arrives after the pointer has moved shows whether the pointer advances past the last owner. Both levels offer a flit in the same cycle, which shows whether priority goes to the lower level. A packet longer than the credit depth, sent while no credits come back, shows whether the port stalls exactly at zero credit. Stray body and idle-kind flits check that unqualified requests are refused. A long random phase with input gaps and random credit returns is compared every cycle against a behavioural model. That comparison separates faults in the interleaving of lanes, in credit arithmetic when a send and a return fall in the same cycle, and in the pointer wrap.

// File: rtl/noc_arb_pkg.sv
package noc_arb_pkg;

  typedef enum logic [1:0] {
    FK_IDLE = 2'b00,
    FK_HEAD = 2'b01,
    FK_BODY = 2'b10,
    FK_TAIL = 2'b11
  } flit_kind_e;

  // kinds that continue a packet already holding a lane
  function automatic logic continues_pkt(input flit_kind_e k);
    return (k == FK_BODY) || (k == FK_TAIL);
  endfunction

endpackage

// File: rtl/noc_sl_credit.sv
module noc_sl_credit #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             give,
  output logic [CNT_W-1:0] count,
  output logic             has_credit
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  assign has_credit = (count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= FULL;
    end else begin
      case ({take, give})
        2'b10:   count <= count - 1'b1;
        2'b01:   count <= count + 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(give && !take && count == FULL));
  assert_no_send_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> count != '0);
  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !give) |=> count == $past(count) - 1'b1);

endmodule

// File: rtl/noc_sl_lane.sv
module noc_sl_lane
  import noc_arb_pkg::*;
#(
  parameter int N_IN  = 5,
  parameter int SL_W  = 1,
  parameter int IDX_W = 3,
  parameter int SL_ID = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_IN-1:0]        req_valid,
  input  logic [N_IN*SL_W-1:0]   req_sl,
  input  logic [N_IN*2-1:0]      req_type,
  input  logic                   fire,
  output logic                   cand_valid,
  output logic [IDX_W-1:0]       cand_idx
);

  logic             locked;
  logic [IDX_W-1:0] owner;
  logic [IDX_W-1:0] rr_ptr;
  logic [N_IN-1:0]  mine;
  logic [N_IN-1:0]  head_req;
  flit_kind_e       kind [N_IN];
  logic             cand_is_head;
  logic             cand_is_tail;

  function automatic logic [IDX_W-1:0] rr_first(input logic [N_IN-1:0] r,
                                                input logic [IDX_W-1:0] p);
    logic [IDX_W-1:0] res;
    logic             found;
    res   = p;
    found = 1'b0;
    for (int k = 0; k < N_IN; k++) begin
      int idx;
      idx = (int'(p) + k) % N_IN;
      if (!found && r[idx]) begin
        found = 1'b1;
        res   = IDX_W'(idx);
      end
    end
    return res;
  endfunction

  function automatic logic [IDX_W-1:0] next_ptr(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(N_IN - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      kind[i]     = flit_kind_e'(req_type[i*2 +: 2]);
      mine[i]     = req_valid[i] && (req_sl[i*SL_W +: SL_W] == SL_W'(SL_ID));
      head_req[i] = mine[i] && (kind[i] == FK_HEAD);
    end
  end

  always_comb begin
    if (locked) begin
      cand_idx   = owner;
      cand_valid = mine[owner] && continues_pkt(kind[owner]);
    end else begin
      cand_idx   = rr_first(head_req, rr_ptr);
      cand_valid = |head_req;
    end
  end

  assign cand_is_head = cand_valid && !locked;
  assign cand_is_tail = cand_valid && locked && (kind[owner] == FK_TAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      owner  <= '0;
      rr_ptr <= '0;
    end else if (fire) begin
      if (cand_is_head) begin
        locked <= 1'b1;
        owner  <= cand_idx;
      end else if (cand_is_tail) begin
        locked <= 1'b0;
        rr_ptr <= next_ptr(owner);
      end
    end
  end

  assert_fire_has_cand_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> cand_valid);
  assert_grant_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !(fire && cand_is_tail)) |=> (locked && $stable(owner)));
  assert_ptr_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cand_is_tail) |=> (!locked && rr_ptr == next_ptr($past(owner))));
  assert_lock_on_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !locked) |=> locked);

endmodule

// File: rtl/noc_sl_prio.sv
module noc_sl_prio #(
  parameter int N_SL = 2,
  parameter int SL_W = 1
) (
  input  logic [N_SL-1:0] elig,
  output logic            any,
  output logic [SL_W-1:0] pick,
  output logic [N_SL-1:0] grant
);

  always_comb begin
    pick = '0;
    for (int s = N_SL - 1; s >= 0; s--) begin
      if (elig[s]) pick = SL_W'(s);
    end
    any   = |elig;
    grant = any ? (N_SL'(1) << pick) : '0;
  end

  always_comb begin
    assert_one_lane_R5: assert ($onehot0(grant));
  end

endmodule

// File: rtl/noc_oport_arb.sv
module noc_oport_arb
  import noc_arb_pkg::*;
#(
  parameter int N_IN         = 5,
  parameter int N_SL         = 2,
  parameter int FLIT_W       = 16,
  parameter int CREDIT_DEPTH = 4,
  localparam int SL_W        = (N_SL > 1) ? $clog2(N_SL) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_IN-1:0]          req_valid,
  input  logic [N_IN*SL_W-1:0]     req_sl,
  input  logic [N_IN*2-1:0]        req_type,
  input  logic [N_IN*FLIT_W-1:0]   req_data,
  input  logic [N_SL-1:0]          credit_ret,
  output logic [N_IN-1:0]          in_ack,
  output logic [N_IN-1:0]          xbar_sel,
  output logic [1:0]               out_type,
  output logic [SL_W-1:0]          out_sl,
  output logic [FLIT_W-1:0]        out_data
);

  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1;
  localparam int CNT_W = $clog2(CREDIT_DEPTH + 1);

  logic [N_SL-1:0]  cand_valid;
  logic [IDX_W-1:0] cand_idx [N_SL];
  logic [N_SL-1:0]  has_credit;
  logic [N_SL-1:0]  elig;
  logic [N_SL-1:0]  fire_vec;
  logic [CNT_W-1:0] credit_cnt [N_SL];
  logic             send_fire;
  logic [SL_W-1:0]  send_sl;
  logic [IDX_W-1:0] send_idx;

  for (genvar s = 0; s < N_SL; s++) begin : g_lane
    noc_sl_lane #(
      .N_IN(N_IN), .SL_W(SL_W), .IDX_W(IDX_W), .SL_ID(s)
    ) lane_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_sl(req_sl), .req_type(req_type),
      .fire(fire_vec[s]),
      .cand_valid(cand_valid[s]), .cand_idx(cand_idx[s])
    );

    noc_sl_credit #(.DEPTH(CREDIT_DEPTH), .CNT_W(CNT_W)) cred_i (
      .clk(clk), .rst_n(rst_n),
      .take(fire_vec[s]), .give(credit_ret[s]),
      .count(credit_cnt[s]), .has_credit(has_credit[s])
    );

    assign elig[s] = cand_valid[s] && has_credit[s];
  end

  noc_sl_prio #(.N_SL(N_SL), .SL_W(SL_W)) prio_i (
    .elig(elig), .any(send_fire), .pick(send_sl), .grant(fire_vec)
  );

  assign send_idx = cand_idx[send_sl];
  assign in_ack   = send_fire ? (N_IN'(1) << send_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xbar_sel <= '0;
      out_type <= FK_IDLE;
      out_sl   <= '0;
      out_data <= '0;
    end else if (send_fire) begin
      xbar_sel <= in_ack;
      out_type <= req_type[send_idx*2 +: 2];
      out_sl   <= send_sl;
      out_data <= req_data[send_idx*FLIT_W +: FLIT_W];
    end else begin
      xbar_sel <= '0;
      out_type <= FK_IDLE;
      out_sl   <= '0;
      out_data <= '0;
    end
  end

  assert_one_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ack));
  assert_ack_then_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_ack) |=> (out_type != FK_IDLE && xbar_sel == $past(in_ack)));
  assert_idle_no_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_type == FK_IDLE) |-> (xbar_sel == '0));
  assert_low_level_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    elig[0] |-> (in_ack != '0 && send_sl == '0));
  assert_ack_is_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_ack & ~req_valid) == '0));

endmodule

// File: tb/noc_oport_arb_tb.sv
module noc_oport_arb_tb_top;

  localparam int N_IN   = 5;
  localparam int N_SL   = 2;
  localparam int FLIT_W = 16;
  localparam int DEPTH  = 4;
  localparam int SL_W   = 1;

  typedef struct {
    int sl;
    int kind;
    int data;
  } flit_t;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [N_IN-1:0]        req_valid = '0;
  logic [N_IN*SL_W-1:0]   req_sl = '0;
  logic [N_IN*2-1:0]      req_type = '0;
  logic [N_IN*FLIT_W-1:0] req_data = '0;
  logic [N_SL-1:0]        credit_ret = '0;
  logic [N_IN-1:0]        in_ack;
  logic [N_IN-1:0]        xbar_sel;
  logic [1:0]             out_type;
  logic [SL_W-1:0]        out_sl;
  logic [FLIT_W-1:0]      out_data;

  noc_oport_arb #(.N_IN(N_IN), .N_SL(N_SL), .FLIT_W(FLIT_W), .CREDIT_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sl(req_sl),
    .req_type(req_type), .req_data(req_data), .credit_ret(credit_ret),
    .in_ack(in_ack), .xbar_sel(xbar_sel), .out_type(out_type),
    .out_sl(out_sl), .out_data(out_data));

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit done     = 0;

  // reference model state
  flit_t q [N_IN][$];
  int lk [N_SL];
  int own [N_SL];
  int ptr [N_SL];
  int cred [N_SL];
  int outstanding [N_SL];
  int exp_type, exp_sl, exp_data, exp_sel;
  int gap_pct = 0;
  int ret_pct = 100;
  int flit_log[$];
  int flits_seen = 0;
  int acks_in4 = 0;
  int acks_in3 = 0;
  bit present [N_IN];

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_fails++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  task automatic model_reset();
    for (int s = 0; s < N_SL; s++) begin
      lk[s] = 0; own[s] = 0; ptr[s] = 0; cred[s] = DEPTH; outstanding[s] = 0;
    end
    exp_type = 0; exp_sl = 0; exp_data = 0; exp_sel = 0;
  endtask

  task automatic step();
    int cand [N_SL];
    int win;
    int ack_exp;
    flit_t f;
    @(negedge clk);
    // R8: registered outputs
    chk(int'(out_type) == exp_type && int'(out_sl) == exp_sl &&
        int'(out_data) == exp_data && int'(xbar_sel) == exp_sel, "R8 output flit",
        {out_type, 7'd0, out_sl, out_data, 3'd0, xbar_sel},
        {exp_type[1:0], 7'd0, exp_sl[0], exp_data[15:0], 3'd0, exp_sel[4:0]});
    if (out_type != 2'b00) begin
      flits_seen++;
      for (int i = 0; i < N_IN; i++) if (xbar_sel[i]) flit_log.push_back(i);
    end
    // drive inputs
    for (int i = 0; i < N_IN; i++) begin
      present[i] = (q[i].size() > 0) && (($urandom % 100) >= gap_pct);
      req_valid[i] = present[i];
      if (present[i]) begin
        f = q[i][0];
        req_sl[i*SL_W +: SL_W]     = SL_W'(f.sl);
        req_type[i*2 +: 2]         = 2'(f.kind);
        req_data[i*FLIT_W +: FLIT_W] = FLIT_W'(f.data);
      end else begin
        req_sl[i*SL_W +: SL_W] = '0;
        req_type[i*2 +: 2] = 2'b00;
        req_data[i*FLIT_W +: FLIT_W] = '0;
      end
    end
    for (int s = 0; s < N_SL; s++)
      credit_ret[s] = (outstanding[s] > 0) && (($urandom % 100) < ret_pct);
    #1;
    // model: candidate per lane
    for (int s = 0; s < N_SL; s++) begin
      cand[s] = -1;
      if (lk[s] != 0) begin
        if (present[own[s]] && q[own[s]][0].sl == s &&
            (q[own[s]][0].kind == 2 || q[own[s]][0].kind == 3)) cand[s] = own[s];
      end else begin
        for (int k = 0; k < N_IN; k++) begin
          int i;
          i = (ptr[s] + k) % N_IN;
          if (cand[s] < 0 && present[i] && q[i][0].sl == s && q[i][0].kind == 1) cand[s] = i;
        end
      end
    end
    win = -1;
    for (int s = 0; s < N_SL; s++)
      if (win < 0 && cand[s] >= 0 && cred[s] > 0) win = s;
    ack_exp = (win >= 0) ? (1 << cand[win]) : 0;
    chk(int'(in_ack) == ack_exp, "R7 in_ack", in_ack, ack_exp);
    if (in_ack[4]) acks_in4++;
    if (in_ack[3]) acks_in3++;
    // model: state update
    for (int s = 0; s < N_SL; s++) begin
      if (credit_ret[s]) begin cred[s]++; outstanding[s]--; end
    end
    if (win >= 0) begin
      int i;
      i = cand[win];
      f = q[i].pop_front();
      cred[win]--; outstanding[win]++;
      if (f.kind == 1) begin lk[win] = 1; own[win] = i; end
      else if (f.kind == 3) begin lk[win] = 0; ptr[win] = (i + 1) % N_IN; end
      exp_type = f.kind; exp_sl = win; exp_data = f.data & 16'hFFFF; exp_sel = 1 << i;
    end else begin
      exp_type = 0; exp_sl = 0; exp_data = 0; exp_sel = 0;
    end
  endtask

  task automatic push_pkt(input int inp, input int sl, input int nbody, input int tagv);
    flit_t f;
    f.sl = sl; f.kind = 1; f.data = tagv; q[inp].push_back(f);
    for (int b = 0; b < nbody; b++) begin
      f.kind = 2; f.data = tagv + b + 1; q[inp].push_back(f);
    end
    f.kind = 3; f.data = tagv + 255; q[inp].push_back(f);
  endtask

  function automatic bit all_empty();
    for (int i = 0; i < N_IN; i++) if (q[i].size() > 0) return 0;
    return 1;
  endfunction

  task automatic run_until_empty(input int limit);
    int n;
    n = 0;
    while (!all_empty() && n < limit) begin step(); n++; end
    chk(all_empty(), "R6 traffic drained", n, limit);
    step(); step();
  endtask

  task automatic settle_credits();
    int n;
    n = 0;
    ret_pct = 100;
    while ((outstanding[0] + outstanding[1]) > 0 && n < 50) begin step(); n++; end
    step();
  endtask

  initial begin
    int expect_seq[$];
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_type == 2'b00 && xbar_sel == '0 && in_ack == '0 && out_sl == '0 && out_data == '0,
        "R1 reset outputs", {out_type, xbar_sel, in_ack}, 0);
    rst_n = 1'b1;
    step(); step();

    // single packet, level 1, input 2
    push_pkt(2, 1, 2, 16'h100);
    flit_log.delete();
    run_until_empty(50);
    chk(flit_log.size() == 4 && flit_log[0] == 2, "R2 single packet source",
        flit_log.size(), 4);

    // R2/R3: three headers on level 0 at once; order 0,1,3, packets unbroken
    settle_credits();
    push_pkt(0, 0, 1, 16'h200);
    push_pkt(1, 0, 2, 16'h300);
    push_pkt(3, 0, 0, 16'h400);
    flit_log.delete();
    run_until_empty(200);
    expect_seq = '{0, 0, 0, 1, 1, 1, 1, 3, 3};
    chk(flit_log == expect_seq, "R3 locked packet order", flit_log.size(), expect_seq.size());
    chk(flit_log.size() > 7 && flit_log[0] == 0 && flit_log[3] == 1 && flit_log[7] == 3,
        "R2 round-robin search order", flit_log.size(), 9);

    // R4: pointer now past input 3 -> input 4 before input 1
    settle_credits();
    push_pkt(1, 0, 0, 16'h500);
    push_pkt(4, 0, 0, 16'h600);
    flit_log.delete();
    run_until_empty(100);
    chk(flit_log.size() == 4 && flit_log[0] == 4 && flit_log[2] == 1,
        "R4 pointer advance", flit_log.size() > 0 ? flit_log[0] : -1, 4);

    // R5: both levels at once, level 0 first
    settle_credits();
    push_pkt(0, 1, 1, 16'h700);
    push_pkt(1, 0, 1, 16'h800);
    flit_log.delete();
    run_until_empty(100);
    chk(flit_log.size() == 6 && flit_log[0] == 1 && flit_log[2] == 1 && flit_log[3] == 0,
        "R5 lower level first", flit_log.size() > 0 ? flit_log[0] : -1, 1);

    // R6: credit stall with no returns
    settle_credits();
    ret_pct = 0;
    push_pkt(2, 0, 4, 16'h900);
    flits_seen = 0;
    repeat (30) step();
    chk(flits_seen == DEPTH, "R6 stall at zero credit", flits_seen, DEPTH);
    ret_pct = 100;
    run_until_empty(100);
    chk(flits_seen == 6, "R6 resume after return", flits_seen, 6);

    // R9: stray body on input 4 and idle-kind on input 3 are refused
    settle_credits();
    begin
      flit_t f;
      f.sl = 0; f.kind = 2; f.data = 16'hAAA; q[4].push_back(f);
      f.sl = 1; f.kind = 0; f.data = 16'hBBB; q[3].push_back(f);
    end
    acks_in4 = 0; acks_in3 = 0;
    repeat (10) step();
    chk(acks_in4 == 0, "R9 body on unlocked lane refused", acks_in4, 0);
    chk(acks_in3 == 0, "R9 idle kind refused", acks_in3, 0);
    q[4].delete(); q[3].delete();
    step(); step();

    // R9: header from a second input while level 1 is locked is refused
    ret_pct = 0;
    begin
      flit_t f;
      f.sl = 1; f.kind = 1; f.data = 16'hC00; q[0].push_back(f);
    end
    step(); step();
    push_pkt(4, 1, 0, 16'hD00);
    acks_in4 = 0;
    repeat (8) step();
    chk(acks_in4 == 0, "R9 header on locked lane refused", acks_in4, 0);
    begin
      flit_t f;
      f.sl = 1; f.kind = 3; f.data = 16'hC01; q[0].push_back(f);
    end
    ret_pct = 100;
    run_until_empty(100);

    // random traffic
    gap_pct = 20;
    ret_pct = 60;
    for (int p = 0; p < 20; p++)
      for (int i = 0; i < N_IN; i++)
        push_pkt(i, int'($urandom % N_SL), int'($urandom % 4), (i << 12) + (p << 4));
    run_until_empty(20000);
    gap_pct = 0;
    settle_credits();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule